// File: doc/BRIEF.md
# Supply-Loss Protection Sequencer

This block guards a battery-backed byte-wide memory while its main supply collapses and returns. It receives two comparator flags that are already digital but asynchronous: one saying the supply has dropped below the level where accesses become unsafe, and one saying it has fallen far enough that the battery must take over. A free-running timebase delivers single-cycle `tick` pulses. Both protection intervals are counted in these ticks.

On a falling supply the sequencer pulls its active-low interrupt at once. This gives the host a short warning window, and accesses still work during that window. Once a fixed number of ticks has passed, the block deselects the memory: every strobe is forced inactive and the battery select may follow the switchover flag. When the supply comes back, the block keeps write protection for a longer recovery interval. It releases the interrupt part way through that interval.

The same block turns the host's two chip enables, write enable and output enable into effective read, write and output-drive strobes. A write is the overlap of all three write conditions, so it begins at the last of them to become active and ends at the first to drop. A one-cycle commit pulse marks each write that the host finished cleanly.

Top module: `pwrfail_guard`

## Requirements
- R1: With `deselect` low, `rd_en` is 1 exactly when `ce1_n`=0, `ce2`=1 and `we_n`=1. `dq_oe` is 1 exactly when `rd_en` is 1 and `oe_n`=0.
- R2: With `deselect` low and the write path armed, `wr_en` is 1 exactly when `ce1_n`=0, `ce2`=1 and `we_n`=0.
- R3: `wr_commit` is high for one cycle, in the cycle after `wr_en` falls because of a host input. It stays low when `wr_en` falls because `deselect` rose.
- R4: During normal operation a rise of `vlow_raw` drives `int_n` low SYNC_STAGES+1 clock edges later. `deselect` and the strobes stay unaffected until the delay has run out.
- R5: `deselect` rises on the edge that takes the DLY_TICKS-th tick after the interrupt was asserted. While `deselect` is high, `rd_en`, `wr_en`, `dq_oe` and `wr_commit` are all 0.
- R6: If the supply returns during the deselect delay, the delay still runs to completion and `deselect` still asserts. A full recovery interval then follows.
- R7: When `vlow_raw` has been low for SYNC_STAGES+1 edges, the block holds `deselect` high for another REC_TICKS ticks. It clears `deselect` on the edge that takes the last of those ticks.
- R8: During recovery, `int_n` returns high after INT_TICKS ticks, which is earlier than `deselect` clears (INT_TICKS < REC_TICKS).
- R9: A fresh supply drop during recovery drives `int_n` low again and keeps `deselect` high. After the next return of the supply, the recovery count starts again from zero.
- R10: `bat_sel` follows the synchronised `vbat_raw` (SYNC_STAGES edges late) only while `deselect` is high. Otherwise it is 0.
- R11: If a host write is still active when protection ends, `wr_en` stays 0 until the host has dropped its write condition for at least one edge.
- R12: Synchronous reset (`rst`=1) leaves `int_n`=1, `deselect`=0 and `bat_sel`=0, with the write path armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle timebase pulse that paces both intervals |
| vlow_raw | input | 1 | Async flag: supply below the deselect level |
| vbat_raw | input | 1 | Async flag: supply below the battery switchover level |
| ce1_n | input | 1 | Host chip enable, active low |
| ce2 | input | 1 | Host chip enable, active high |
| we_n | input | 1 | Host write enable, active low |
| oe_n | input | 1 | Host output enable, active low |
| int_n | output | 1 | Power-fail interrupt, active low (0 = pull the open-drain line low) |
| deselect | output | 1 | Internal deselect and write protect |
| bat_sel | output | 1 | Select the battery as the supply source |
| rd_en | output | 1 | Effective read strobe |
| wr_en | output | 1 | Effective write strobe |
| dq_oe | output | 1 | Data output drive enable |
| wr_commit | output | 1 | One-cycle pulse after a write that the host ended |

## Verification
Random host control codes, mixed with random ticks and battery flags, are applied in normal operation. They cover every combination of the four enables, so they separate read from write from output drive. Each change in that stream also shows whether a commit pulse is present or absent. Directed sequences then cover four cases:
- a write held straight through a supply drop, which separates an aborted write from a committed one;
- a supply that returns inside the warning window, which shows that the delay still runs to completion;
- a second drop in mid-recovery, which shows that the recovery count restarts;
- a write held across the end of protection, which shows that the write path must be re-armed.

// File: rtl/pwrfail_pkg.sv
package pwrfail_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_WARN = 2'd1,
        ST_DOWN = 2'd2,
        ST_REC  = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic ce1_n;
        logic ce2;
        logic we_n;
        logic oe_n;
    } host_ctl_t;

    typedef struct packed {
        logic rd;
        logic wr;
        logic oe;
        logic commit;
    } strobe_t;

    function automatic logic host_selected(host_ctl_t h);
        return !h.ce1_n && h.ce2;
    endfunction

    function automatic logic host_writing(host_ctl_t h);
        return host_selected(h) && !h.we_n;
    endfunction

    function automatic logic state_protected(seq_state_e s);
        return (s == ST_DOWN) || (s == ST_REC);
    endfunction

endpackage

// File: rtl/pfs_sync.sv
module pfs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pfs_tick_cnt.sv
module pfs_tick_cnt #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             tick,
    output logic [WIDTH-1:0] cnt
);
    localparam logic [WIDTH-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst || clr)                   cnt <= '0;
        else if (tick && cnt != CNT_MAX)  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pfs_seq.sv
module pfs_seq
    import pwrfail_pkg::*;
#(
    parameter int DLY_TICKS = 3,
    parameter int REC_TICKS = 40,
    parameter int INT_TICKS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic vlow,
    input  logic vbat,
    output logic int_n_o,
    output logic desel_o,
    output logic bat_sel_o
);
    localparam int CNT_TOP = (DLY_TICKS > REC_TICKS) ? DLY_TICKS : REC_TICKS;
    localparam int CW      = $clog2(CNT_TOP + 1);
    localparam logic [CW-1:0] DLY_LAST = CW'(DLY_TICKS - 1);
    localparam logic [CW-1:0] REC_LAST = CW'(REC_TICKS - 1);
    localparam logic [CW-1:0] INT_LIM  = CW'(INT_TICKS);

    seq_state_e state, nxt;
    logic [CW-1:0] cnt;
    logic cnt_clr;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN:  if (vlow) nxt = ST_WARN;
            ST_WARN: if (tick && cnt == DLY_LAST) nxt = ST_DOWN;
            ST_DOWN: if (!vlow) nxt = ST_REC;
            ST_REC: begin
                if (vlow)                           nxt = ST_DOWN;
                else if (tick && cnt == REC_LAST)   nxt = ST_RUN;
            end
            default: nxt = ST_RUN;
        endcase
    end

    assign cnt_clr = (nxt != state);

    always_ff @(posedge clk) begin
        if (rst) state <= ST_RUN;
        else     state <= nxt;
    end

    pfs_tick_cnt #(.WIDTH(CW)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .clr  (cnt_clr),
        .tick (tick),
        .cnt  (cnt)
    );

    always_comb begin
        unique case (state)
            ST_RUN:  int_n_o = 1'b1;
            ST_REC:  int_n_o = (cnt >= INT_LIM);
            default: int_n_o = 1'b0;
        endcase
    end

    assign desel_o   = state_protected(state);
    assign bat_sel_o = desel_o && vbat;

    // R4: a drop seen while running pulls the interrupt on the next edge
    assert_int_prompt_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && vlow) |=> !int_n_o);

    // R5: protection only ever begins after the interrupt has been low
    assert_desel_after_int_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(desel_o) |-> $past(!int_n_o));

    // R8: the interrupt is released before protection ends
    assert_int_released_first_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(desel_o) |-> int_n_o);

    // R9: a renewed drop in recovery holds protection
    assert_refail_holds_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_REC && vlow) |=> (desel_o && !int_n_o));
endmodule

// File: rtl/pfs_gate.sv
module pfs_gate
    import pwrfail_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  host_ctl_t host,
    input  logic      desel,
    output strobe_t   stb
);
    logic armed;
    logic wr_q;

    always_ff @(posedge clk) begin
        if (rst)                        armed <= 1'b1;
        else if (desel)                 armed <= 1'b0;
        else if (!host_writing(host))   armed <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) wr_q <= 1'b0;
        else     wr_q <= stb.wr;
    end

    always_comb begin
        stb.rd     = host_selected(host) && host.we_n && !desel;
        stb.wr     = host_writing(host) && armed && !desel;
        stb.oe     = stb.rd && !host.oe_n;
        stb.commit = wr_q && !stb.wr && !desel;
    end

    // R3: a commit pulse follows a cycle in which writing was active
    assert_commit_follows_write_R3: assert property (@(posedge clk) disable iff (rst)
        stb.commit |-> $past(stb.wr));

    // R11: the first unprotected cycle never carries a stale write
    assert_rearm_needed_R11: assert property (@(posedge clk) disable iff (rst)
        $fell(desel) |-> !stb.wr);
endmodule

// File: rtl/pwrfail_guard.sv
module pwrfail_guard
    import pwrfail_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DLY_TICKS   = 3,
    parameter int REC_TICKS   = 40,
    parameter int INT_TICKS   = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic vlow_raw,
    input  logic vbat_raw,
    input  logic ce1_n,
    input  logic ce2,
    input  logic we_n,
    input  logic oe_n,
    output logic int_n,
    output logic deselect,
    output logic bat_sel,
    output logic rd_en,
    output logic wr_en,
    output logic dq_oe,
    output logic wr_commit
);
    localparam int NFLAG = 2;

    logic [NFLAG-1:0] flag_raw, flag_syn;
    host_ctl_t host;
    strobe_t   stb;

    assign flag_raw = {vbat_raw, vlow_raw};

    generate
        for (genvar i = 0; i < NFLAG; i++) begin : g_sync
            pfs_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk (clk),
                .rst (rst),
                .d   (flag_raw[i]),
                .q   (flag_syn[i])
            );
        end
    endgenerate

    pfs_seq #(
        .DLY_TICKS (DLY_TICKS),
        .REC_TICKS (REC_TICKS),
        .INT_TICKS (INT_TICKS)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .vlow      (flag_syn[0]),
        .vbat      (flag_syn[1]),
        .int_n_o   (int_n),
        .desel_o   (deselect),
        .bat_sel_o (bat_sel)
    );

    assign host = '{ce1_n: ce1_n, ce2: ce2, we_n: we_n, oe_n: oe_n};

    pfs_gate u_gate (
        .clk   (clk),
        .rst   (rst),
        .host  (host),
        .desel (deselect),
        .stb   (stb)
    );

    assign rd_en     = stb.rd;
    assign wr_en     = stb.wr;
    assign dq_oe     = stb.oe;
    assign wr_commit = stb.commit;

    // R5: nothing reaches the memory while protected
    assert_no_access_protected_R5: assert property (@(posedge clk) disable iff (rst)
        deselect |-> !(rd_en || wr_en || dq_oe || wr_commit));

    // R10: the battery is only chosen once the memory is protected
    assert_bat_needs_protect_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(bat_sel) |-> deselect);
endmodule

// File: tb/sim_pwrfail_guard.sv
`timescale 1ns/1ps
module sim_pwrfail_guard;
    localparam int SYNC = 2;
    localparam int DLY  = 4;
    localparam int REC  = 12;
    localparam int INTT = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0, vlow_raw = 1'b0, vbat_raw = 1'b0;
    logic ce1_n = 1'b1, ce2 = 1'b0, we_n = 1'b1, oe_n = 1'b1;
    logic int_n, deselect, bat_sel, rd_en, wr_en, dq_oe, wr_commit;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pwrfail_guard #(
        .SYNC_STAGES (SYNC), .DLY_TICKS (DLY), .REC_TICKS (REC), .INT_TICKS (INTT)
    ) u0 (
        .clk (clk), .rst (rst), .tick (tick), .vlow_raw (vlow_raw), .vbat_raw (vbat_raw),
        .ce1_n (ce1_n), .ce2 (ce2), .we_n (we_n), .oe_n (oe_n),
        .int_n (int_n), .deselect (deselect), .bat_sel (bat_sel),
        .rd_en (rd_en), .wr_en (wr_en), .dq_oe (dq_oe), .wr_commit (wr_commit)
    );

    function automatic logic f_rd(logic c1n, logic c2, logic wn);
        return !c1n && c2 && wn;
    endfunction
    function automatic logic f_wr(logic c1n, logic c2, logic wn);
        return !c1n && c2 && !wn;
    endfunction
    function automatic logic f_oe(logic c1n, logic c2, logic wn, logic on);
        return f_rd(c1n, c2, wn) && !on;
    endfunction

    task automatic chk(input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", what, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            step();
            tick = 1'b0;
        end
    endtask

    task automatic host_idle();
        ce1_n = 1'b1; ce2 = 1'b0; we_n = 1'b1; oe_n = 1'b1;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<50000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic prev_wr;
        logic exp_wr;
        void'($urandom(32'h1D2C_5EED));
        steps(4);
        rst = 1'b0;
        step();

        // R12 reset state
        chk(int_n, 1'b1, "R12 int_n after reset");
        chk(deselect, 1'b0, "R12 deselect after reset");
        chk(bat_sel, 1'b0, "R12 bat_sel after reset");
        chk(wr_en | rd_en | dq_oe | wr_commit, 1'b0, "R12 strobes idle after reset");

        // R1 R2 R3 R10: random host codes during normal operation
        prev_wr = 1'b0;
        for (int it = 0; it < 300; it++) begin
            logic [31:0] r;
            r = $urandom;
            ce1_n = r[0]; ce2 = r[1]; we_n = r[2]; oe_n = r[3];
            tick = r[4]; vbat_raw = r[5];
            #1;
            exp_wr = f_wr(ce1_n, ce2, we_n);
            chk(rd_en, f_rd(ce1_n, ce2, we_n), "R1 rd_en random");
            chk(dq_oe, f_oe(ce1_n, ce2, we_n, oe_n), "R1 dq_oe random");
            chk(wr_en, exp_wr, "R2 wr_en random");
            chk(wr_commit, prev_wr && !exp_wr, "R3 wr_commit random");
            chk(bat_sel, 1'b0, "R10 bat_sel ignored while running");
            prev_wr = exp_wr;
            @(posedge clk);
            #1;
        end
        tick = 1'b0; vbat_raw = 1'b0;
        host_idle();
        steps(3);

        // R4 R5 R3: write held straight through a supply drop
        ce1_n = 1'b0; ce2 = 1'b1; we_n = 1'b0;
        step();
        vlow_raw = 1'b1;
        steps(SYNC);
        chk(int_n, 1'b1, "R4 int_n not yet low before sync latency");
        step();
        chk(int_n, 1'b0, "R4 int_n low after sync latency");
        chk(deselect, 1'b0, "R4 no deselect at warning start");
        chk(wr_en, 1'b1, "R4 write still allowed in warning");
        ticks(DLY - 1);
        chk(deselect, 1'b0, "R5 deselect waits for last delay tick");
        ticks(1);
        chk(deselect, 1'b1, "R5 deselect on last delay tick");
        chk(wr_en, 1'b0, "R5 wr_en blocked when protected");
        chk(wr_commit, 1'b0, "R3 aborted write gives no commit");
        step();
        chk(wr_commit, 1'b0, "R3 no late commit after abort");
        we_n = 1'b1; oe_n = 1'b0;
        #1;
        chk(rd_en | dq_oe, 1'b0, "R5 read blocked when protected");
        we_n = 1'b0; oe_n = 1'b1;

        // R10 battery select while protected
        vbat_raw = 1'b1;
        step();
        chk(bat_sel, 1'b0, "R10 bat_sel waits for sync");
        step();
        chk(bat_sel, 1'b1, "R10 bat_sel follows flag when protected");
        vbat_raw = 1'b0;
        steps(SYNC);
        chk(bat_sel, 1'b0, "R10 bat_sel drops with flag");

        // R7 R8 R9 R11: recovery with a renewed drop, write still held
        vlow_raw = 1'b0;
        steps(SYNC + 1);
        chk(deselect, 1'b1, "R7 protection held at recovery start");
        ticks(INTT - 1);
        chk(int_n, 1'b0, "R8 int_n low before release count");
        ticks(1);
        chk(int_n, 1'b1, "R8 int_n released after release count");
        chk(deselect, 1'b1, "R8 deselect still high at int release");
        vlow_raw = 1'b1;
        steps(SYNC + 1);
        chk(int_n, 1'b0, "R9 int_n low on renewed drop");
        chk(deselect, 1'b1, "R9 deselect held on renewed drop");
        vlow_raw = 1'b0;
        steps(SYNC + 1);
        ticks(REC - 1);
        chk(deselect, 1'b1, "R9 recovery count restarted");
        chk(int_n, 1'b1, "R8 int_n released late in recovery");
        ticks(1);
        chk(deselect, 1'b0, "R7 deselect clears on last recovery tick");
        chk(wr_en, 1'b0, "R11 held write not resumed");
        we_n = 1'b1;
        #1;
        chk(wr_commit, 1'b0, "R3 no commit for unarmed write");
        step();
        we_n = 1'b0;
        #1;
        chk(wr_en, 1'b1, "R11 write allowed after host release");
        step();
        we_n = 1'b1;
        #1;
        chk(wr_commit, 1'b1, "R3 commit after host ends write");
        step();
        chk(wr_commit, 1'b0, "R3 commit lasts one cycle");
        host_idle();
        steps(2);

        // R6: supply returns inside the warning window
        vlow_raw = 1'b1;
        steps(SYNC + 1);
        chk(int_n, 1'b0, "R6 warning entered");
        vlow_raw = 1'b0;
        steps(SYNC + 1);
        chk(deselect, 1'b0, "R6 still in warning after return");
        chk(int_n, 1'b0, "R6 int_n kept low after return");
        ticks(DLY - 1);
        chk(deselect, 1'b0, "R6 delay not cut short");
        ticks(1);
        chk(deselect, 1'b1, "R6 deselect completes");
        step();
        ticks(REC - 1);
        chk(deselect, 1'b1, "R6 full recovery runs");
        ticks(1);
        chk(deselect, 1'b0, "R6 recovery ends after full count");
        chk(int_n, 1'b1, "R6 int_n released at end");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule